// File: doc/BRIEF.md
# Parity-Guarded Serial Command Register Slave

This block is a serial peripheral slave, clocked from the chip's system clock, that takes 16-bit command frames from a host controller. It writes a 4-bit data nibble into a small register file. Every write is screened twice. First, the command code (address plus direction bits) must be one of a sparse set of legal codes, chosen so that no single bit error can turn one legal code into another. Second, the nibble must come with four matching parity bits. Frames that fail either test change nothing and raise a sticky error flag. The host can read the flag back through a status register.

The operating mode of the surrounding chip is driven from a pair of registers: a mode control register and its confirming twin. The mode output moves only when the control register is written and the twin is then written with the same nibble. Every transfer also returns a response frame. While the host clocks in frame N, the block clocks out the code of frame N-1, the register value that frame N-1 addressed, and parity over that value. The serial pins are sampled through synchronizers, so the serial clock must be several times slower than the system clock.

Top module: `psr_spi_slave`

## Requirements
- R1: Frames are 16 bits, most significant bit first, in SPI mode 0 with active-low select. Bits 15..10 are the address, bits 9..8 are the direction (2'b10 write, 2'b01 read), bits 7..4 are parity and bits 3..0 are data. MOSI is captured on rising serial-clock edges and MISO changes after falling edges.
- R2: The expected parity is computed from data d as bit7 = d3^d0, bit6 = d3^d2, bit5 = d2^d1 and bit4 = d1^d0. A write with a legal code and matching parity stores d in the addressed register.
- R3: A write with a legal code and mismatching parity leaves every register and the mode unchanged and sets the error flag.
- R4: The legal addresses are 6'b000011 (mode control), 6'b000101 (mode confirm), 6'b000110 (status, read-only; writes to it are ignored without error) and 6'b001001 (user data). Any other address, or a direction of 2'b00 or 2'b11, changes no register and sets the error flag. Flipping any one of the 8 code bits of a legal code always yields an illegal code.
- R5: A frame is acted on only when select rises after exactly 16 rising serial-clock edges. Any other count causes no write and no error, and leaves the pending response unchanged.
- R6: After an accepted mode-control write of value v, an accepted mode-confirm write of the same v sets the mode output to v.
- R7: A mode-confirm write whose value differs from the control register keeps the mode. So does a mode-confirm write that is not preceded by a fresh mode-control write since the last confirm write.
- R8: The response shifted out during a frame is {previous address, previous direction, parity of v per R2, v}. Here v is the value the previous frame's register held before that frame acted, or 0 when the previous code was illegal. The status value is {error flag, confirm-pending, 0, 0}.
- R9: The error flag stays set until a status read. That read returns the flag as 1 in its response and then clears it.
- R10: While reset is low, all registers, the mode output (normal-request mode, 0), the error flag, the pending response and MISO are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial response data to host |
| op_mode | output | 4 | Confirmed operating mode |
| err_flag | output | 1 | Sticky frame error flag |

## Verification
Select and serial clock each pass through two synchronizer stages and one edge-detect stage before the register bank acts. Registers, the mode output and the error flag therefore settle about four system clocks after select rises. The bench waits twelve system clocks after releasing select before it reads those ports. MISO changes about four system clocks after each falling serial-clock edge, and the bench samples it just before the next rising edge, eight system clocks later. Register contents are checked one frame late, through the response that R8 defines, against a model the bench updates from the requirements after each complete frame.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int ADDR_W  = 6;
  localparam int DIR_W   = 2;
  localparam int NIB_W   = 4;
  localparam int FRAME_W = ADDR_W + DIR_W + 2 * NIB_W;

  // sparse code set: every address has even weight, so one flipped bit is illegal
  localparam logic [ADDR_W-1:0] ADR_MCTL = 6'b000011;
  localparam logic [ADDR_W-1:0] ADR_MCNF = 6'b000101;
  localparam logic [ADDR_W-1:0] ADR_STAT = 6'b000110;
  localparam logic [ADDR_W-1:0] ADR_USER = 6'b001001;
  localparam logic [DIR_W-1:0]  DIR_WR   = 2'b10;
  localparam logic [DIR_W-1:0]  DIR_RD   = 2'b01;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MCTL = 3'd1,
    SEL_MCNF = 3'd2,
    SEL_STAT = 3'd3,
    SEL_USER = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DIR_W-1:0]  dir;
    logic [NIB_W-1:0]  par;
    logic [NIB_W-1:0]  data;
  } frame_t;

  // four check bits over the nibble
  function automatic logic [NIB_W-1:0] nib_parity(input logic [NIB_W-1:0] d);
    return {d[3] ^ d[0], d[3] ^ d[2], d[2] ^ d[1], d[1] ^ d[0]};
  endfunction

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_MCTL: return SEL_MCTL;
      ADR_MCNF: return SEL_MCNF;
      ADR_STAT: return SEL_STAT;
      ADR_USER: return SEL_USER;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/psr_spi_port.sv
module psr_spi_port #(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               miso,
  output logic [FRAME_W-1:0] rx_word,
  output logic               frame_done,
  output logic               frame_abort
);
  localparam int               CNT_W    = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam int               N_SYNC   = 3;
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b010; // select idles high

  logic [N_SYNC-1:0] raw_in, synced;
  assign raw_in = {mosi, cs_n, sck};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= {SYNC_STAGES{SYNC_RST[g]}};
      else        stage_q <= {stage_q[SYNC_STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = stage_q[SYNC_STAGES-1];
  end

  logic sck_s, cs_s, mosi_s, sck_q, cs_q;
  assign sck_s  = synced[0];
  assign cs_s   = synced[1];
  assign mosi_s = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, sel_start, sel_end;
  assign sck_rise  = sck_s & ~sck_q & ~cs_s;
  assign sck_fall  = ~sck_s & sck_q & ~cs_s;
  assign sel_start = ~cs_s & cs_q;
  assign sel_end   = cs_s & ~cs_q;

  logic [CNT_W-1:0]   edge_cnt;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic               active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      active   <= 1'b0;
    end else begin
      if (sel_start) begin
        edge_cnt <= '0;
        tx_sh    <= tx_word;
        active   <= 1'b1;
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
          if (edge_cnt != CNT_SAT) edge_cnt <= edge_cnt + 1'b1;
        end
        if (sck_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (sel_end) active <= 1'b0;
      end
    end
  end

  assign miso        = active & tx_sh[FRAME_W-1];
  assign rx_word     = rx_sh;
  assign frame_done  = sel_end & (edge_cnt == CNT_FULL);
  assign frame_abort = sel_end & (edge_cnt != CNT_FULL);
endmodule

// File: rtl/psr_frame_check.sv
module psr_frame_check
  import psr_pkg::*;
(
  input  frame_t   frame,
  output reg_sel_e sel,
  output logic     is_write,
  output logic     code_ok,
  output logic     parity_ok
);
  logic dir_legal;
  assign sel       = decode_addr(frame.addr);
  assign dir_legal = (frame.dir == DIR_WR) || (frame.dir == DIR_RD);
  assign code_ok   = (sel != SEL_NONE) && dir_legal;
  assign is_write  = (frame.dir == DIR_WR);
  assign parity_ok = (nib_parity(frame.data) == frame.par);
endmodule

// File: rtl/psr_reg_bank.sv
module psr_reg_bank
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DIR_W-1:0]   dir,
  input  logic [NIB_W-1:0]   data,
  input  reg_sel_e           sel,
  input  logic               is_write,
  input  logic               code_ok,
  input  logic               parity_ok,
  output logic [NIB_W-1:0]   op_mode,
  output logic               err_flag,
  output logic [FRAME_W-1:0] resp_word,
  output logic [NIB_W-1:0]   mctl_q,
  output logic [NIB_W-1:0]   user_q,
  output logic               wr_accept,
  output logic               cnf_commit,
  output logic               stat_read
);
  logic [NIB_W-1:0] mcnf_q, read_val, resp_data;
  logic             pend_q, flag_set;

  always_comb begin
    case (sel)
      SEL_MCTL: read_val = mctl_q;
      SEL_MCNF: read_val = mcnf_q;
      SEL_STAT: read_val = {err_flag, pend_q, 2'b00};
      SEL_USER: read_val = user_q;
      default:  read_val = '0;
    endcase
  end

  assign resp_data  = code_ok ? read_val : '0;
  assign wr_accept  = frame_done & code_ok & is_write & parity_ok;
  assign flag_set   = frame_done & (~code_ok | (is_write & ~parity_ok));
  assign stat_read  = frame_done & code_ok & ~is_write & (sel == SEL_STAT);
  assign cnf_commit = wr_accept & (sel == SEL_MCNF) & pend_q & (data == mctl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl_q    <= '0;
      mcnf_q    <= '0;
      user_q    <= '0;
      pend_q    <= 1'b0;
      op_mode   <= '0;
      err_flag  <= 1'b0;
      resp_word <= '0;
    end else begin
      if (frame_done) resp_word <= {addr, dir, nib_parity(resp_data), resp_data};
      if (flag_set)       err_flag <= 1'b1;
      else if (stat_read) err_flag <= 1'b0;
      if (wr_accept) begin
        case (sel)
          SEL_MCTL: begin
            mctl_q <= data;
            pend_q <= 1'b1;
          end
          SEL_MCNF: begin
            mcnf_q <= data;
            pend_q <= 1'b0;
          end
          SEL_USER: user_q <= data;
          default: ;
        endcase
      end
      if (cnf_commit) op_mode <= data;
    end
  end
endmodule

// File: rtl/psr_spi_slave.sv
module psr_spi_slave
  import psr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic [NIB_W-1:0] op_mode,
  output logic             err_flag
);
  logic [FRAME_W-1:0] rx_word, resp_word;
  logic               frame_done, frame_abort;
  frame_t             rx_frame;
  reg_sel_e           sel;
  logic               is_write, code_ok, parity_ok;
  logic [NIB_W-1:0]   mctl_q, user_q;
  logic               wr_accept, cnf_commit, stat_read, cnf_hit;

  psr_spi_port #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(resp_word), .miso(spi_miso), .rx_word(rx_word),
    .frame_done(frame_done), .frame_abort(frame_abort)
  );

  assign rx_frame = frame_t'(rx_word);

  psr_frame_check u_check (
    .frame(rx_frame), .sel(sel), .is_write(is_write),
    .code_ok(code_ok), .parity_ok(parity_ok)
  );

  psr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .addr(rx_frame.addr), .dir(rx_frame.dir), .data(rx_frame.data),
    .sel(sel), .is_write(is_write), .code_ok(code_ok), .parity_ok(parity_ok),
    .op_mode(op_mode), .err_flag(err_flag), .resp_word(resp_word),
    .mctl_q(mctl_q), .user_q(user_q), .wr_accept(wr_accept),
    .cnf_commit(cnf_commit), .stat_read(stat_read)
  );

  assign cnf_hit = (sel == SEL_MCNF);
endmodule

// File: rtl/psr_spi_slave_chk.sv
module psr_spi_slave_chk
  import psr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NIB_W-1:0]   op_mode,
  input logic               err_flag,
  input logic [NIB_W-1:0]   user_q,
  input logic [NIB_W-1:0]   mctl_q,
  input logic [FRAME_W-1:0] resp_word,
  input logic [NIB_W-1:0]   rx_data,
  input logic               frame_done,
  input logic               frame_abort,
  input logic               is_write,
  input logic               parity_ok,
  input logic               wr_accept,
  input logic               cnf_hit,
  input logic               cnf_commit,
  input logic               stat_read
);
  assert_mode_needs_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_mode) |-> $past(cnf_commit));

  assert_bad_parity_no_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && is_write && !parity_ok) |=> $stable(user_q));

  assert_flag_raised_by_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(frame_done));

  assert_flag_cleared_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(stat_read));

  assert_abort_keeps_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> $stable(resp_word));

  assert_mismatch_keeps_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && cnf_hit && (rx_data != mctl_q)) |=> $stable(op_mode));
endmodule

bind psr_spi_slave psr_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .err_flag(err_flag),
  .user_q(user_q), .mctl_q(mctl_q), .resp_word(resp_word),
  .rx_data(rx_frame.data), .frame_done(frame_done), .frame_abort(frame_abort),
  .is_write(is_write), .parity_ok(parity_ok), .wr_accept(wr_accept),
  .cnf_hit(cnf_hit), .cnf_commit(cnf_commit), .stat_read(stat_read)
);

// File: tb/psr_spi_slave_tb.sv
`timescale 1ns/1ps
module psr_spi_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, err;
  logic [3:0] mode;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  psr_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .op_mode(mode), .err_flag(err)
  );

  // requirement-level model
  logic [3:0]  m_ctl, m_cnf, m_user, m_mode;
  logic        m_pend, m_err;
  logic [15:0] m_resp;

  localparam logic [5:0] A_CTL = 6'b000011, A_CNF = 6'b000101,
                         A_STA = 6'b000110, A_USR = 6'b001001;

  function automatic logic [3:0] par_of(input logic [3:0] d);
    return d ^ {d[0], d[3:1]}; // xor with the nibble rotated right
  endfunction

  function automatic logic [15:0] mk(input logic [5:0] a, input logic [1:0] rw,
                                     input logic [3:0] d);
    return {a, rw, par_of(d), d};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = 0; m_cnf = 0; m_user = 0; m_mode = 0; m_pend = 0; m_err = 0; m_resp = 0;
  endtask

  task automatic model_step(input logic [15:0] w);
    logic [5:0] a; logic [1:0] rw; logic [3:0] d, v; logic ok;
    a = w[15:10]; rw = w[9:8]; d = w[3:0];
    ok = (a == A_CTL || a == A_CNF || a == A_STA || a == A_USR) && (rw == 2'b10 || rw == 2'b01);
    v = 4'h0;
    if (ok) begin
      if (a == A_CTL) v = m_ctl;
      else if (a == A_CNF) v = m_cnf;
      else if (a == A_STA) v = {m_err, m_pend, 2'b00};
      else v = m_user;
    end
    m_resp = {a, rw, par_of(v), v};
    if (!ok) m_err = 1'b1;
    else if (rw == 2'b10) begin
      if (w[7:4] != par_of(d)) m_err = 1'b1;
      else if (a == A_CTL) begin m_ctl = d; m_pend = 1'b1; end
      else if (a == A_CNF) begin
        if (m_pend && d == m_ctl) m_mode = d;
        m_cnf = d; m_pend = 1'b0;
      end else if (a == A_USR) m_user = d;
    end else if (a == A_STA) m_err = 1'b0;
  endtask

  // one transfer of nbits edges; response checked only on full frames
  task automatic xfer(input logic [15:0] w, input int nbits, input string req);
    logic [15:0] r;
    r = 16'h0;
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15 - i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) r = {r[14:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits == 16) begin
      check(r, m_resp, {"R8 response ", req});
      model_step(w);
    end
    check({15'h0, err}, {15'h0, m_err}, {"R9 flag ", req});
    check({12'h0, mode}, {12'h0, m_mode}, {"R6 mode ", req});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (6) @(negedge clk);
    model_reset();
    check({12'h0, mode}, 16'h0, "R10 mode at reset");
    check({15'h0, err},  16'h0, "R10 flag at reset");
    check({15'h0, miso}, 16'h0, "R10 miso at reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(900_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2: store every nibble in the user register, read back via next response
    for (int d = 0; d < 16; d++) xfer(mk(A_USR, 2'b10, 4'(d)), 16, "R2 user write");
    xfer(mk(A_USR, 2'b01, 4'h0), 16, "R1 user read");
    // R3: every nibble with each single parity bit wrong, then status read R9
    for (int d = 0; d < 16; d++)
      for (int b = 0; b < 4; b++) begin
        xfer(mk(A_USR, 2'b10, 4'(d)) ^ (16'h0010 << b), 16, "R3 bad parity");
        xfer(mk(A_STA, 2'b01, 4'h0), 16, "R9 status read");
      end
    xfer(mk(A_USR, 2'b01, 4'h0), 16, "R3 user kept");
    // R4: every single-bit flip of every legal write code
    for (int c = 0; c < 4; c++)
      for (int b = 8; b < 16; b++) begin
        logic [5:0] a;
        a = (c == 0) ? A_CTL : (c == 1) ? A_CNF : (c == 2) ? A_STA : A_USR;
        xfer(mk(a, 2'b10, 4'h6) ^ (16'h1 << b), 16, "R4 code flip");
        xfer(mk(A_STA, 2'b01, 4'h0), 16, "R4 status read");
      end
    xfer(mk(A_USR, 2'b00, 4'h7), 16, "R4 dir 00");
    xfer(mk(A_USR, 2'b11, 4'h7), 16, "R4 dir 11");
    xfer(mk(A_STA, 2'b10, 4'h7), 16, "R4 status write ignored");
    xfer(mk(A_STA, 2'b01, 4'h0), 16, "R9 status read");
    xfer(mk(A_USR, 2'b01, 4'h0), 16, "R4 user kept");
    // R5: short and long frames do nothing
    xfer(mk(A_USR, 2'b10, 4'h3), 15, "R5 short frame");
    xfer(mk(A_USR, 2'b10, 4'h3), 17, "R5 long frame");
    xfer(mk(A_USR, 2'b01, 4'h0), 16, "R5 user kept");
    // R6 R7: mode confirmation rules
    xfer(mk(A_CNF, 2'b10, 4'h5), 16, "R7 confirm without control");
    xfer(mk(A_CTL, 2'b10, 4'h5), 16, "R6 control");
    xfer(mk(A_CNF, 2'b10, 4'h5), 16, "R6 confirm");
    xfer(mk(A_CTL, 2'b10, 4'h9), 16, "R7 control");
    xfer(mk(A_CNF, 2'b10, 4'h3), 16, "R7 mismatched confirm");
    xfer(mk(A_CNF, 2'b10, 4'h9), 16, "R7 stale confirm");
    for (int v = 0; v < 16; v++) begin
      xfer(mk(A_CTL, 2'b10, 4'(15 - v)), 16, "R6 control sweep");
      xfer(mk(A_CNF, 2'b10, 4'(15 - v)), 16, "R6 confirm sweep");
    end
    xfer(mk(A_CTL, 2'b10, 4'hC), 16, "R6 control");
    xfer(mk(A_CTL, 2'b01, 4'h0), 16, "R8 control read");
    xfer(mk(A_CNF, 2'b01, 4'h0), 16, "R8 confirm read");
    xfer(mk(A_STA, 2'b01, 4'h0), 16, "R8 status pending");
    // R10: reset again mid-run
    xfer(mk(A_USR, 2'b00, 4'h1), 16, "R10 set flag");
    do_reset();
    xfer(mk(A_USR, 2'b01, 4'h0), 16, "R10 first response");
    xfer(mk(A_CTL, 2'b01, 4'h0), 16, "R10 user cleared");
    xfer(mk(A_STA, 2'b01, 4'h0), 16, "R10 control cleared");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule